// File: doc/BRIEF.md
# Cascadable Serial Bitstream Reader

This block is the read side of a serial configuration store. It holds a fixed array of bits and an address counter. On each rising edge of the serial clock it hands the next stored bit to a device that is being configured. The contents come from a seed parameter through a fixed arithmetic pattern, which stands in for a separately programmed array. A combined reset/output-enable input clears the counter and holds the data pad undriven. A configuration input selects whether the active level of that input is high or low. A low level on the serial-enable input selects programming mode, and the read stream pauses there.

Instances can be chained. The cascade-enable output of one instance drives the chip-enable input of the next. On the clock edge that consumes its last bit, an instance stops driving and pulls cascade-enable low, so the next instance takes over from its own bit 0. The data output is split into a value and a pad-drive enable, and a pad cell forms the shared three-state line from the two. A ready flag reports that the internal reset has been released and the block is not in programming mode.

Top module: `bitstream_reader`

## Requirements
- R1: Bit k of the array is the XOR of the bits of ((k*37 + SEED) mod 65536) AND 0x00E7. With chip-enable low, reset/enable inactive and serial-enable high, the k-th bit after a clear appears on `data_o` with `data_oe_o` high.
- R2: `rstoe_pol_i` = 0 makes `rstoe_i` active when high, and `rstoe_pol_i` = 1 makes it active when low.
- R3: While `rstoe_i` is at its active level, `data_oe_o` is low. The next rising edge returns the counter to bit 0 and sets `ceo_no` high.
- R4: The counter advances by one bit on each rising edge only while chip-enable is low, reset/enable is inactive, serial-enable is high and the end has not been reached. In every other case it holds, and streaming resumes at the same bit.
- R5: On the edge that consumes the last bit, `ceo_no` falls and `data_oe_o` drops. Both stay that way for as long as reset/enable remains inactive.
- R6: While `ce_ni` is high, `data_oe_o` is low and the counter holds.
- R7: While `prog_ni` is low, `data_oe_o` and `ready_o` are low and the counter holds.
- R8: Two instances chained through `ceo_no` to `ce_ni` deliver the whole upstream array followed by the whole downstream array, with no gap and no overlap.
- R9: If reset/enable is active on the cycle that presents the last bit, the clear wins: `ceo_no` stays high and the stream restarts at bit 0.
- R10: While `rst_ni` is low, `ready_o` is low, `ceo_no` is high and `data_oe_o` is low. `ready_o` rises after the second rising edge following the release, provided `prog_ni` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; bits advance on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_ni | input | 1 | Chip enable, active low; high means standby |
| rstoe_i | input | 1 | Combined counter reset / output enable |
| rstoe_pol_i | input | 1 | 0: `rstoe_i` active high; 1: active low |
| prog_ni | input | 1 | Serial-enable; low selects programming mode |
| data_o | output | 1 | Current bit value, valid while `data_oe_o` is high |
| data_oe_o | output | 1 | Pad drive enable for the shared data line |
| ceo_no | output | 1 | Cascade enable to the next device, active low |
| ready_o | output | 1 | Internal reset released and not in programming mode |

## Verification
The clear from the reset/enable input and the last-bit handoff can fall on the same clock edge. The bench provokes this by driving reset/enable active exactly on the cycle in which the upstream instance presents its final bit, and again on the cycle in which the downstream instance presents its final bit. In both cases it then expects cascade-enable to be high again and the chain to restart at the first upstream bit, not to hand off. It runs this under both polarity settings, with standby gaps and programming-mode pauses placed inside the stream.

// File: rtl/brd_pkg.sv
package brd_pkg;

  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } rstoe_pol_e;

  // Stored pattern: parity of a scrambled index under a fixed mask
  function automatic logic pattern_bit(input int unsigned idx, input logic [15:0] seed);
    logic [15:0] v;
    v = 16'(idx * 32'd37) + seed;
    return ^(v & 16'h00E7);
  endfunction

endpackage

// File: rtl/brd_rst_sync.sv
module brd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/brd_enable.sv
module brd_enable (
  input  logic run_i,
  input  logic ce_ni,
  input  logic rstoe_i,
  input  logic rstoe_pol_i,
  input  logic prog_ni,
  input  logic done_i,
  output logic clr_o,
  output logic adv_o,
  output logic drive_o
);
  import brd_pkg::*;

  logic act;
  logic live;

  always_comb begin
    act     = (rstoe_pol_i == POL_ACT_LOW) ? ~rstoe_i : rstoe_i;
    live    = run_i & ~ce_ni & ~act & prog_ni & ~done_i;
    clr_o   = act;
    adv_o   = live;
    drive_o = live;
  end
endmodule

// File: rtl/brd_addr_ctr.sv
module brd_addr_ctr #(
  parameter int DEPTH = 512,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              upd;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    upd    = clr_i | adv_i;
    if (clr_i) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (adv_i) begin
      if (addr_q == LAST) done_d = 1'b1;
      else                addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/brd_bit_rom.sv
module brd_bit_rom #(
  parameter int          DEPTH = 512,
  parameter logic [15:0] SEED  = 16'h5A3C,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o
);
  logic [DEPTH-1:0] content;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign content[i] = brd_pkg::pattern_bit(i, SEED);
  end

  assign bit_o = content[addr_i];
endmodule

// File: rtl/bitstream_reader.sv
module bitstream_reader #(
  parameter int          DEPTH = 512,
  parameter logic [15:0] SEED  = 16'h5A3C,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic rstoe_i,
  input  logic rstoe_pol_i,
  input  logic prog_ni,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no,
  output logic ready_o
);
  logic              rst_sync_n;
  logic              clr, adv, drive;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rom_bit;

  brd_rst_sync #(.STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  brd_enable u_en (
    .run_i      (rst_sync_n),
    .ce_ni      (ce_ni),
    .rstoe_i    (rstoe_i),
    .rstoe_pol_i(rstoe_pol_i),
    .prog_ni    (prog_ni),
    .done_i     (done_q),
    .clr_o      (clr),
    .adv_o      (adv),
    .drive_o    (drive)
  );

  brd_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .clr_i (clr),
    .adv_i (adv),
    .addr_o(addr_q),
    .done_o(done_q)
  );

  brd_bit_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
    .addr_i(addr_q),
    .bit_o (rom_bit)
  );

  assign data_o    = drive & rom_bit;
  assign data_oe_o = drive;
  assign ceo_no    = ~done_q;
  assign ready_o   = rst_sync_n & prog_ni;
endmodule

// File: rtl/bitstream_reader_chk.sv
module bitstream_reader_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              ce_ni,
  input logic              rstoe_i,
  input logic              rstoe_pol_i,
  input logic              prog_ni,
  input logic              data_oe_o,
  input logic              ceo_no,
  input logic              ready_o,
  input logic [ADDR_W-1:0] addr
);
  logic act;
  assign act = rstoe_pol_i ? ~rstoe_i : rstoe_i;

  // R6
  standby_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ce_ni |-> !data_oe_o);

  // R7
  prog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !prog_ni |-> (!data_oe_o && !ready_o));

  // R3
  clear_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    act |=> (ceo_no && addr == '0));

  // R4
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!act && (ce_ni || !prog_ni)) |=> ($stable(addr) && $stable(ceo_no)));

  // R5
  end_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!act && !ceo_no) |=> !ceo_no);

  // R5
  handoff_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(ceo_no) |-> !data_oe_o);
endmodule

bind bitstream_reader bitstream_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .ce_ni      (ce_ni),
  .rstoe_i    (rstoe_i),
  .rstoe_pol_i(rstoe_pol_i),
  .prog_ni    (prog_ni),
  .data_oe_o  (data_oe_o),
  .ceo_no     (ceo_no),
  .ready_o    (ready_o),
  .addr       (addr_q)
);

// File: tb/bitstream_reader_test.sv
`timescale 1ns/1ps
module bitstream_reader_test;
  localparam int          D  = 32;
  localparam logic [15:0] SA = 16'h1234;
  localparam logic [15:0] SB = 16'h00C5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ce_n, rstoe, pol, prog_n;
  logic da, oea, ceoa, rdya;
  logic db, oeb, ceob, rdyb;
  int   nvec, nfail, k;

  bitstream_reader #(.DEPTH(D), .SEED(SA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rstoe_i(rstoe),
    .rstoe_pol_i(pol), .prog_ni(prog_n), .data_o(da), .data_oe_o(oea),
    .ceo_no(ceoa), .ready_o(rdya));

  bitstream_reader #(.DEPTH(D), .SEED(SB)) uut_dn (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ceoa), .rstoe_i(rstoe),
    .rstoe_pol_i(pol), .prog_ni(prog_n), .data_o(db), .data_oe_o(oeb),
    .ceo_no(ceob), .ready_o(rdyb));

  function automatic logic exp_bit(input int idx, input logic [15:0] seed);
    logic [15:0] v;
    v = 16'(idx * 37) + seed;
    return ^(v & 16'h00E7);
  endfunction

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic tick(input logic ce_v, input logic act_v, input logic prog_v);
    logic  a_on, b_on;
    string up_req, dn_req;
    ce_n   = ce_v;
    rstoe  = pol ? ~act_v : act_v;
    prog_n = prog_v;
    #1;
    a_on = !ce_v && !act_v && prog_v && (k < D);
    b_on = !act_v && prog_v && (k >= D) && (k < 2*D);
    if (act_v)          begin up_req = pol ? "R2" : "R3"; dn_req = up_req; end
    else if (!prog_v)   begin up_req = "R7"; dn_req = "R7"; end
    else begin
      up_req = (k >= D) ? "R5" : (ce_v ? "R6" : "R4");
      dn_req = (k >= 2*D) ? "R5" : ((k < D) ? "R6" : "R8");
    end
    chk(up_req, "oe_up", oea, a_on);
    chk(dn_req, "oe_dn", oeb, b_on);
    if (a_on) chk("R1", "data_up", da, exp_bit(k, SA));
    if (b_on) chk("R8", "data_dn", db, exp_bit(k - D, SB));
    chk("R5", "ceo_up", ceoa, !(k >= D));
    chk("R5", "ceo_dn", ceob, !(k >= 2*D));
    chk(prog_v ? "R10" : "R7", "ready", rdya, prog_v);
    @(posedge clk);
    if (act_v) k = 0;
    else if (prog_v && ((k < D && !ce_v) || (k >= D && k < 2*D))) k++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    nvec = 0; nfail = 0; k = 0;
    rst_n = 1'b0; ce_n = 1'b1; pol = 1'b0; rstoe = 1'b1; prog_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10", "ready_rst", rdya, 1'b0);
    chk("R10", "ceo_up_rst", ceoa, 1'b1);
    chk("R10", "ceo_dn_rst", ceob, 1'b1);
    chk("R10", "oe_up_rst", oea, 1'b0);
    chk("R10", "oe_dn_rst", oeb, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10", "ready_1edge", rdya, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R10", "ready_2edge", rdya, 1'b1);

    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      tick(1'b1, 1'b1, 1'b1);   // R6 standby with reset level active
      tick(1'b0, 1'b1, 1'b1);
      tick(1'b0, 1'b1, 1'b1);
      // Full chained stream with standby and programming pauses (R1 R4 R6 R7 R8)
      for (int i = 0; i < 2*D + 20; i++) begin
        tick((i >= 6 && i <= 8), 1'b0, !(i == 3 || i == 40 || i == 41));
      end
      chk("R8", "stream_len", (k == 2*D), 1'b1);
      // R9 clear on the upstream last-bit cycle
      tick(1'b0, 1'b1, 1'b1);
      while (k < D - 1) tick(1'b0, 1'b0, 1'b1);
      tick(1'b0, 1'b1, 1'b1);
      chk("R9", "ceo_up_after_clear", ceoa, 1'b1);
      chk("R9", "restart_at_0", (k == 0), 1'b1);
      // R9 clear on the downstream last-bit cycle
      while (k < 2*D - 1) tick(1'b0, 1'b0, 1'b1);
      tick(1'b0, 1'b1, 1'b1);
      chk("R9", "ceo_dn_after_clear", ceob, 1'b1);
      chk("R9", "ceo_up_after_clear2", ceoa, 1'b1);
    end

    summary();
    $finish;
  end
endmodule